// File: doc/BRIEF.md
# I2C Target Bus Engine with Firmware Clock Stretch

This block is the target (slave) side of an I2C bus. It watches the clock and data lines through open-drain inputs and pulls them low through open-drain outputs. It detects START and STOP conditions and compares the address byte against a programmed 7-bit address. In 10-bit mode it compares a two-byte address instead. After a match it either takes in data bytes or sends out data bytes, and it handles the acknowledge bit of every byte.

Firmware reaches the engine through a small word-wide register port. One register holds the control bits:
- three interrupt enables;
- a one-shot "refuse the next byte" bit;
- a level-held clock-stretch bit;
- the 10-bit mode select.

Two registers hold the address. A shared data offset carries the byte to send (write) and the last byte received (read). A flags offset collects the byte-sent, byte-received and STOP events, and firmware clears each flag by writing a one to it. The interrupt output is high while any flag is set whose enable is also set.

Top module: `i2ct_top`

## Requirements
- R1: After reset every register reads zero, neither line is pulled and `irq` is low. In the control word at offset 0, only bits [5:0] exist. Writing all ones reads back 0x003F, and bits [15:6] always read zero.
- R2: In 7-bit mode (control bit 5 = 0) the engine answers an address byte with ACK (SDA pulled low in the ninth clock) exactly when bits [7:1] of the byte equal offset 1 bits [6:0]. Any other address gets no response, and the engine stays silent until the next START. Right after a START, SDA is released.
- R3: After a matched write address, each data byte is ACKed and becomes readable at offset 3. Receiving it sets the byte-received flag, which is flags bit 1 at offset 4.
- R4: After a matched read address (R/W bit = 1), the engine sends the byte last written to offset 3, MSB first. It sets the byte-sent flag (flags bit 0) after the eighth bit. It sends again after a master ACK and falls silent after a master NACK.
- R5: In 10-bit mode (control bit 5 = 1) the first address byte must equal 11110, then offset 1 bits [1:0], then 0. The second address byte must equal offset 2. Each byte is ACKed only when it matches. A mismatch leaves the engine silent.
- R6: Control bit 3 makes the engine leave SDA released in the acknowledge slot of the next byte it would otherwise ACK. The bit clears itself when that slot ends, so the following transfer is ACKed again.
- R7: When control bit 4 (stretch) is set while SCL is high, SCL is not pulled at once. It is pulled and held low starting from the next falling edge of SCL.
- R8: When stretch is set while SCL is low, SCL is held low within a few cycles. Clearing stretch releases SCL.
- R9: `irq` equals the OR of the flags gated by their enables: control bit 0 for byte-sent, bit 1 for byte-received and bit 2 for STOP. Writing a one to a flag bit at offset 4 clears that flag.
- R10: A STOP on the bus sets flags bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| scl_pull | output | 1 | High pulls the clock line low |
| sda_pull | output | 1 | High pulls the data line low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset (0 control, 1 address high, 2 address low, 3 data, 4 flags) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the stretch request made while SCL is high. The engine must not touch the line until the master itself drives the clock low, and only then hold it. The bench sets the stretch bit while the modelled master keeps SCL released and confirms that nothing is pulled. The master then issues one low pulse, and the bench checks that the line stays low after the master lets go. The one-shot refusal is reached by arming it after an address has already been ACKed, so that it lands on a data byte. The bench then sends a second transfer to show that the bit has gone.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   localparam int BYTE_W = 8;

   // register offsets
   localparam logic [2:0] OFS_CTRL  = 3'd0;
   localparam logic [2:0] OFS_AHI   = 3'd1;
   localparam logic [2:0] OFS_ALO   = 3'd2;
   localparam logic [2:0] OFS_DATA  = 3'd3;
   localparam logic [2:0] OFS_FLAGS = 3'd4;

   // control bit positions
   localparam int C_TXIE    = 0;
   localparam int C_RXIE    = 1;
   localparam int C_STOPIE  = 2;
   localparam int C_NACK    = 3;
   localparam int C_STRETCH = 4;
   localparam int C_TEN     = 5;
   localparam int CTRL_BITS = 6;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR1, ST_ADDR2, ST_RX, ST_ACK, ST_TX, ST_TACK, ST_WAIT
   } eng_state_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  stg[i] <= '1;
            else if (i == 0) stg[i] <= d;
            else         stg[i] <= stg[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2ct_linecond.sv
module i2ct_linecond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_stretch.sv
module i2ct_stretch (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic scl_s,
   output logic hold
);
   // a request seen while the clock is high waits until the clock is seen low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold <= 1'b0;
      else        hold <= enable & (hold | ~scl_s);
   end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
   import i2ct_pkg::*;
#(
   parameter bit TEN_BIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              ten_mode,
   input  logic              nack_req,
   input  logic [6:0]        addr_hi,
   input  logic [BYTE_W-1:0] addr_lo,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              sda_low,
   output logic              rx_pulse,
   output logic [BYTE_W-1:0] rx_data,
   output logic              tx_pulse,
   output logic              nack_done
);
   eng_state_t        st, nxt;
   logic [2:0]        cnt;
   logic [BYTE_W-1:0] sh;
   logic              full, nack_slot, m_ack;
   logic              hit1, hit2, ten_sel;

   generate
      if (TEN_BIT) begin : g_ten
         assign ten_sel = ten_mode;
         assign hit1 = ten_mode ? (sh == {5'b11110, addr_hi[1:0], 1'b0})
                                : (sh[7:1] == addr_hi);
         assign hit2 = (sh == addr_lo);
      end else begin : g_seven
         logic unused_ten;
         assign unused_ten = ten_mode ^ (^addr_lo);
         assign ten_sel = 1'b0;
         assign hit1 = (sh[7:1] == addr_hi);
         assign hit2 = 1'b0;
      end
   endgenerate

   assign rx_data = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  nxt <= ST_IDLE;  cnt <= '0;  sh <= '0;
         full <= 1'b0;   sda_low <= 1'b0; nack_slot <= 1'b0; m_ack <= 1'b0;
         rx_pulse <= 1'b0; tx_pulse <= 1'b0; nack_done <= 1'b0;
      end else begin
         rx_pulse  <= 1'b0;
         tx_pulse  <= 1'b0;
         nack_done <= 1'b0;
         if (start_ev) begin
            st <= ST_ADDR1; cnt <= '0; full <= 1'b0;
            sda_low <= 1'b0; nack_slot <= 1'b0;
         end else if (stop_ev) begin
            st <= ST_IDLE; full <= 1'b0; sda_low <= 1'b0;
         end else begin
            case (st)
               ST_ADDR1, ST_ADDR2, ST_RX: begin
                  if (scl_rise && !full) begin
                     sh   <= {sh[BYTE_W-2:0], sda_s};
                     cnt  <= cnt + 3'd1;
                     full <= (cnt == 3'd7);
                  end else if (scl_fall && full) begin
                     full <= 1'b0;
                     cnt  <= '0;
                     if (st == ST_RX) begin
                        rx_pulse  <= 1'b1;
                        st        <= ST_ACK;
                        sda_low   <= !nack_req;
                        nack_slot <= nack_req;
                        nxt       <= nack_req ? ST_WAIT : ST_RX;
                     end else if ((st == ST_ADDR1 && hit1) || (st == ST_ADDR2 && hit2)) begin
                        st        <= ST_ACK;
                        sda_low   <= !nack_req;
                        nack_slot <= nack_req;
                        if (nack_req)                      nxt <= ST_WAIT;
                        else if (st == ST_ADDR1 && ten_sel) nxt <= ST_ADDR2;
                        else if (st == ST_ADDR1 && sh[0])   nxt <= ST_TX;
                        else                                nxt <= ST_RX;
                     end else begin
                        st <= ST_WAIT;
                     end
                  end
               end
               ST_ACK: if (scl_fall) begin
                  st        <= nxt;
                  nack_done <= nack_slot;
                  nack_slot <= 1'b0;
                  cnt       <= '0;
                  if (nxt == ST_TX) begin
                     sh      <= tx_byte;
                     sda_low <= ~tx_byte[BYTE_W-1];
                  end else begin
                     sda_low <= 1'b0;
                  end
               end
               ST_TX: if (scl_fall) begin
                  if (cnt == 3'd7) begin
                     sda_low  <= 1'b0;
                     st       <= ST_TACK;
                     tx_pulse <= 1'b1;
                  end else begin
                     cnt     <= cnt + 3'd1;
                     sh      <= {sh[BYTE_W-2:0], 1'b0};
                     sda_low <= ~sh[BYTE_W-2];
                  end
               end
               ST_TACK: begin
                  if (scl_rise) m_ack <= ~sda_s;
                  else if (scl_fall) begin
                     if (m_ack) begin
                        st      <= ST_TX;
                        cnt     <= '0;
                        sh      <= tx_byte;
                        sda_low <= ~tx_byte[BYTE_W-1];
                     end else begin
                        st <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
   import i2ct_pkg::*;
#(
   parameter int AW = 3,
   parameter int DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic              rx_pulse,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              tx_pulse,
   input  logic              stop_pulse,
   input  logic              nack_done,
   output logic [CTRL_BITS-1:0] ctrl,
   output logic [6:0]        addr_hi,
   output logic [BYTE_W-1:0] addr_lo,
   output logic [BYTE_W-1:0] tx_byte,
   output logic [2:0]        flags,
   output logic              irq
);
   logic [BYTE_W-1:0] rx_q;
   logic [2:0]        set_v;
   logic              unused_hi;

   assign unused_hi = ^wdata[DW-1:BYTE_W];
   assign set_v     = {stop_pulse, rx_pulse, tx_pulse};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0; addr_hi <= '0; addr_lo <= '0;
         tx_byte <= '0; rx_q <= '0; flags <= '0;
      end else begin
         if (wr && addr == AW'(OFS_CTRL))  ctrl    <= wdata[CTRL_BITS-1:0];
         if (nack_done)                    ctrl[C_NACK] <= 1'b0;
         if (wr && addr == AW'(OFS_AHI))   addr_hi <= wdata[6:0];
         if (wr && addr == AW'(OFS_ALO))   addr_lo <= wdata[BYTE_W-1:0];
         if (wr && addr == AW'(OFS_DATA))  tx_byte <= wdata[BYTE_W-1:0];
         if (rx_pulse)                     rx_q    <= rx_data;
         if (wr && addr == AW'(OFS_FLAGS)) flags   <= (flags & ~wdata[2:0]) | set_v;
         else                              flags   <= flags | set_v;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(OFS_CTRL):  rdata[CTRL_BITS-1:0] = ctrl;
         AW'(OFS_AHI):   rdata[6:0]           = addr_hi;
         AW'(OFS_ALO):   rdata[BYTE_W-1:0]    = addr_lo;
         AW'(OFS_DATA):  rdata[BYTE_W-1:0]    = rx_q;
         AW'(OFS_FLAGS): rdata[2:0]           = flags;
         default:        rdata = '0;
      endcase
   end

   assign irq = |(flags & ctrl[C_STOPIE:C_TXIE]);
endmodule

// File: rtl/i2ct_top.sv
module i2ct_top
   import i2ct_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit TEN_BIT     = 1'b1,
   parameter int REG_AW      = 3,
   parameter int REG_DW      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_pull,
   output logic              sda_pull,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [REG_DW-1:0] bus_wdata,
   output logic [REG_DW-1:0] bus_rdata,
   output logic              irq
);
   localparam int LINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2ct_top: SYNC_STAGES must be at least 2");
      end
      if (REG_AW < 3) begin : g_bad_aw
         $error("i2ct_top: REG_AW must be at least 3");
      end
      if (REG_DW < 16) begin : g_bad_dw
         $error("i2ct_top: REG_DW must be at least 16");
      end
   endgenerate

   logic [LINES-1:0]     lines_s;
   logic                 scl_s, sda_s;
   logic                 scl_rise, scl_fall, start_ev, stop_ev;
   logic [CTRL_BITS-1:0] ctrl;
   logic                 ctrl_stretch;
   logic [6:0]           addr_hi;
   logic [BYTE_W-1:0]    addr_lo, tx_byte, rx_data;
   logic                 rx_pulse, tx_pulse, nack_done;
   logic [2:0]           flags;

   i2ct_sync #(.STAGES(SYNC_STAGES), .W(LINES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s));
   assign scl_s = lines_s[1];
   assign sda_s = lines_s[0];

   i2ct_linecond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev));

   assign ctrl_stretch = ctrl[C_STRETCH];

   i2ct_stretch u_str (
      .clk(clk), .rst_n(rst_n), .enable(ctrl_stretch), .scl_s(scl_s), .hold(scl_pull));

   i2ct_engine #(.TEN_BIT(TEN_BIT)) u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev),
      .ten_mode(ctrl[C_TEN]), .nack_req(ctrl[C_NACK]),
      .addr_hi(addr_hi), .addr_lo(addr_lo), .tx_byte(tx_byte),
      .sda_low(sda_pull), .rx_pulse(rx_pulse), .rx_data(rx_data),
      .tx_pulse(tx_pulse), .nack_done(nack_done));

   i2ct_regs #(.AW(REG_AW), .DW(REG_DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata),
      .rx_pulse(rx_pulse), .rx_data(rx_data), .tx_pulse(tx_pulse),
      .stop_pulse(stop_ev), .nack_done(nack_done),
      .ctrl(ctrl), .addr_hi(addr_hi), .addr_lo(addr_lo),
      .tx_byte(tx_byte), .flags(flags), .irq(irq));
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       stretch_en,
   input logic       scl_level,
   input logic       scl_pull,
   input logic       start_seen,
   input logic       stop_seen,
   input logic       sda_pull,
   input logic [2:0] flags
);
   // R7: a request made while the clock is high does not pull the line yet
   assert_defer_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stretch_en && !scl_pull && scl_level) |=> !scl_pull);

   // R8: once held, the clock stays held while the request remains
   assert_keep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stretch_en && scl_pull) |=> scl_pull);

   // R8: clearing the request lets go of the clock
   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!stretch_en) |=> !scl_pull);

   // R2: a START always leaves the data line released
   assert_start_frees_sda_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_seen |=> !sda_pull);

   // R10: a STOP sets its flag
   assert_stop_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> flags[2]);
endmodule

bind i2ct_top i2ct_checker u_chk (
   .clk(clk), .rst_n(rst_n), .stretch_en(ctrl_stretch), .scl_level(scl_s),
   .scl_pull(scl_pull), .start_seen(start_ev), .stop_seen(stop_ev),
   .sda_pull(sda_pull), .flags(flags));

// File: tb/i2ct_top_test.sv
module i2ct_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int H = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic        scl_in, sda_in, scl_pull, sda_pull;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign scl_in = ~(m_scl_low | scl_pull);
   assign sda_in = ~(m_sda_low | sda_pull);

   i2ct_top uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_pull(scl_pull), .sda_pull(sda_pull), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk); bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic m_start();
      m_sda_low = 1'b0; m_scl_low = 1'b0; waitc(H);
      m_sda_low = 1'b1; waitc(H);
      m_scl_low = 1'b1; waitc(H);
   endtask

   task automatic m_stop();
      m_sda_low = 1'b1; waitc(H);
      m_scl_low = 1'b0; waitc(H);
      m_sda_low = 1'b0; waitc(H);
   endtask

   task automatic m_bit(input logic b, output logic r);
      m_sda_low = ~b; waitc(H);
      m_scl_low = 1'b0; waitc(H);
      r = sda_in;
      m_scl_low = 1'b1; waitc(H);
   endtask

   task automatic m_wbyte(input logic [7:0] v, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) m_bit(v[i], r);
      m_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic m_rbits(output logic [7:0] v);
      logic r;
      for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); v[i] = r; end
   endtask

   initial begin
      logic [15:0] d;
      logic        ack, r;
      logic [7:0]  v, exp_b;
      waitc(4); rst_n = 1'b1; waitc(2);

      // R1 reset state
      for (int a = 0; a < 5; a++) begin rd(3'(a), d); check("R1 reset reg", d, 0); end
      check("R1 scl_pull", scl_pull, 0);
      check("R1 sda_pull", sda_pull, 0);
      check("R1 irq", irq, 0);
      wr(3'd0, 16'hFFFF); rd(3'd0, d); check("R1 reserved", d, 16'h003F);
      wr(3'd0, 16'h0000);

      // R2 sweep of all 7-bit addresses against target 0x2A
      wr(3'd1, 16'h002A);
      for (int x = 0; x < 128; x++) begin
         m_start(); m_wbyte({7'(x), 1'b0}, ack); m_stop();
         check($sformatf("R2 addr 0x%0h ack", x), ack, (x == 'h2A) ? 1 : 0);
      end

      // R3 data bytes, R9 clear
      wr(3'd4, 16'h0007);
      m_start(); m_wbyte(8'h54, ack); check("R3 addr ack", ack, 1);
      for (int k = 0; k < 8; k++) begin
         exp_b = 8'(k * 8'h35 + 8'h0F);
         m_wbyte(exp_b, ack);
         check("R3 data ack", ack, 1);
         rd(3'd3, d); check("R3 data value", d, exp_b);
         rd(3'd4, d); check("R3 rx flag", d, 16'h0002);
         wr(3'd4, 16'h0002); rd(3'd4, d); check("R9 clear rx flag", d, 0);
      end
      m_stop();
      rd(3'd4, d); check("R10 stop flag", d, 16'h0004);
      wr(3'd4, 16'h0004);

      // R9 interrupt gating
      wr(3'd0, 16'h0002);
      m_start(); m_wbyte(8'h54, ack); m_wbyte(8'h99, ack);
      check("R9 irq enabled", irq, 1);
      wr(3'd4, 16'h0002); check("R9 irq cleared", irq, 0);
      wr(3'd0, 16'h0000);
      m_wbyte(8'h11, ack);
      check("R9 irq masked", irq, 0);
      wr(3'd0, 16'h0004); waitc(1);
      check("R9 irq stale stop", irq, 0);
      m_stop();
      check("R9 irq stop enabled", irq, 1);
      wr(3'd0, 16'h0000); wr(3'd4, 16'h0007);

      // R4 transmit
      wr(3'd3, 16'h00A5);
      m_start(); m_wbyte(8'h55, ack); check("R4 read addr ack", ack, 1);
      m_rbits(v); check("R4 first byte", v, 8'hA5);
      rd(3'd4, d); check("R4 tx flag", d, 16'h0001);
      wr(3'd3, 16'h003C);
      m_bit(1'b0, r);
      m_rbits(v); check("R4 second byte", v, 8'h3C);
      m_bit(1'b1, r);
      m_rbits(v); check("R4 silent after nack", v, 8'hFF);
      m_stop();
      wr(3'd4, 16'h0007);

      // R6 one-shot refusal
      m_start(); m_wbyte(8'h54, ack); check("R6 addr ack", ack, 1);
      wr(3'd0, 16'h0008);
      m_wbyte(8'h42, ack); check("R6 refused byte", ack, 0);
      rd(3'd0, d); check("R6 bit self clears", d, 0);
      m_stop();
      m_start(); m_wbyte(8'h54, ack); m_wbyte(8'h43, ack);
      check("R6 next byte acked", ack, 1);
      m_stop();

      // R5 ten-bit addressing
      wr(3'd0, 16'h0020); wr(3'd1, 16'h0002); wr(3'd2, 16'h005C);
      m_start(); m_wbyte(8'hF4, ack); check("R5 header ack", ack, 1);
      m_wbyte(8'h5C, ack); check("R5 low byte ack", ack, 1);
      m_wbyte(8'h77, ack); check("R5 data ack", ack, 1);
      rd(3'd3, d); check("R5 data value", d, 8'h77);
      m_stop();
      m_start(); m_wbyte(8'hF4, ack); m_wbyte(8'h5D, ack);
      check("R5 wrong low byte", ack, 0); m_stop();
      m_start(); m_wbyte(8'hF2, ack); check("R5 wrong header", ack, 0); m_stop();
      m_start(); m_wbyte(8'hF5, ack); check("R5 header read bit", ack, 0); m_stop();
      wr(3'd0, 16'h0000);

      // R7 stretch requested while SCL high
      wr(3'd0, 16'h0010); waitc(10);
      check("R7 no pull while high", scl_pull, 0);
      m_scl_low = 1'b1; waitc(10); m_scl_low = 1'b0; waitc(6);
      check("R7 held after fall", scl_pull, 1);
      check("R7 line low", scl_in, 0);
      // R8 release and immediate hold
      wr(3'd0, 16'h0000); waitc(3);
      check("R8 released", scl_pull, 0);
      check("R8 line high", scl_in, 1);
      m_scl_low = 1'b1; waitc(6);
      wr(3'd0, 16'h0010); waitc(4);
      check("R8 hold while low", scl_pull, 1);
      m_scl_low = 1'b0; waitc(6);
      check("R8 line kept low", scl_in, 0);
      wr(3'd0, 16'h0000); waitc(3);
      check("R8 released again", scl_in, 1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule